// File: doc/BRIEF.md
# Serial Audio Stereo Transmitter

This block sends stereo audio samples one bit at a time on a serial data line. An external bit clock sets the rate. A word-select line marks each slot: it is low while the left sample is sent and high while the right sample is sent. The bit clock is sampled in the system clock domain, and a falling edge is seen when `sck` is high at one system clock edge and low at the next. Every output change happens at that system clock edge.

A host loads each channel through its own 24-bit holding register. When a slot begins, that channel's holding register is copied into the shifter. Two empty flags show which holding registers are waiting for new data. Three interrupt requests are decoded from the flags: left needs data, right needs data, and underrun. During an underrun the stale sample is sent again.

A control word sets the slot length to 16, 24 or 32 bits. It also holds a padding control for 32-bit slots and the request enable. A software reset clears the padding control and the request enable.

Top module: `sat_tx`

## Requirements
- R1: After `rst_n` is low at a clock edge, the outputs are as follows: `ws`=1, `sdo`=0, both empty flags are 1, all three requests are 0, and the control word is 0 (16-bit slots, no padding, requests disabled).
- R2: `sdo` and `ws` change only at a bit-clock falling edge. The first falling edge after reset starts a left slot. `ws` is 0 for every bit of a left slot and 1 for every bit of a right slot. Each slot starts with the most significant bit of its sample.
- R3: The length field is `ctrl_din[1:0]`: 00 gives 16-bit slots, 01 gives 24-bit slots, and 10 or 11 gives 32-bit slots. A 16-bit slot sends sample bits 23 down to 8. A 24-bit slot sends bits 23 down to 0.
- R4: In a 32-bit slot with the padding control (`ctrl_din[2]`) at 0, bits 23 down to 0 are sent, and then bit 0 is sent 8 more times.
- R5: In a 32-bit slot with the padding control at 1, bit 23 is sent 8 times, and then bits 23 down to 0 are sent.
- R6: In 16-bit and 24-bit slots the padding control has no effect on the serial stream.
- R7: A channel's empty flag sets when that channel's holding register is copied into the shifter at the start of its slot. The flag clears one edge after the host writes that channel. If the write and the copy fall on the same edge, the shifter takes the old content and the flag ends up clear.
- R8: If a slot starts while its holding register has not been written since the last copy, the previous sample of that channel is sent again.
- R9: The request enable is `ctrl_din[3]`. With the enable set, `irq_left` is 1 when only the left flag is set, `irq_right` is 1 when only the right flag is set, and `irq_under` is 1 when both flags are set. At most one request is active at a time.
- R10: The empty flags report holding-register status whether the request enable is set or clear.
- R11: Writing the request enable to 0 does not remove a pending request in the cycle the write is presented. The request is gone after the next clock edge.
- R12: A `soft_rst` pulse clears the padding control and the request enable. The slot length, the holding registers, the flags and the framing are left unchanged. A software reset takes priority over a control write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Bit clock, synchronous to `clk` and slower than it |
| soft_rst | input | 1 | Software reset of the control word fields |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_din | input | 4 | {request enable, padding control, length[1:0]} |
| wr_left | input | 1 | Write `wdata` to the left holding register |
| wr_right | input | 1 | Write `wdata` to the right holding register |
| wdata | input | 24 | Sample to store |
| sdo | output | 1 | Serial data |
| ws | output | 1 | Word select, 0 = left slot, 1 = right slot |
| left_empty | output | 1 | Left holding register awaits data |
| right_empty | output | 1 | Right holding register awaits data |
| irq_left | output | 1 | Left channel needs data |
| irq_right | output | 1 | Right channel needs data |
| irq_under | output | 1 | Both channels empty, stale data being resent |

## Verification
- **Serial outputs:** `sdo` and `ws` settle at the same clock edge that samples `sck` low after it was high.
- **Flags and control:** host writes and control writes take effect at the first clock edge that sees the strobe.
- **Requests:** the requests are decoded straight from the stored enable and flags, so they follow those registers with no further delay. A cleared enable is therefore still visible while the write is being presented and gone after that edge.
- **Sampling:** the bench drives every input at a falling clock edge and reads the outputs at the next falling edge, after exactly one rising edge has acted. It reads once more immediately after presenting the enable write, to confirm the request is still present.

// File: rtl/sat_pkg.sv
// Shared types and helpers for the serial audio transmitter.
// Assumes the sample width is greater than the short slot and pad widths.
package sat_pkg;
    localparam int SAMPLE_W = 24;
    localparam int PAD_W    = 8;
    localparam int SHORT_W  = 16;
    localparam int SLOT_MAX = SAMPLE_W + PAD_W;
    localparam int CNT_W    = $clog2(SLOT_MAX);
    localparam int CHANNELS = 2;

    localparam logic [CNT_W-1:0] TOP_POS    = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] PAD_CNT    = CNT_W'(PAD_W);
    localparam logic [CNT_W-1:0] SAMPLE_CNT = CNT_W'(SAMPLE_W);

    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,
        LEN_FULL  = 2'b01,
        LEN_LONG  = 2'b10,
        LEN_LONG2 = 2'b11
    } slot_len_e;

    typedef struct packed {
        logic      irq_en;
        logic      expand;
        slot_len_e len;
    } ctrl_t;

    // Last bit index of a slot for a given length code
    function automatic logic [CNT_W-1:0] last_index(input slot_len_e len);
        case (len)
            LEN_SHORT: return CNT_W'(SHORT_W - 1);
            LEN_FULL:  return CNT_W'(SAMPLE_W - 1);
            default:   return CNT_W'(SLOT_MAX - 1);
        endcase
    endfunction

    // Serial bit sent at position idx of a slot carrying sample s
    function automatic logic slot_bit(input logic [SAMPLE_W-1:0] s,
                                      input logic [CNT_W-1:0] idx,
                                      input slot_len_e len,
                                      input logic xp);
        logic [CNT_W-1:0]    pos;
        logic [SAMPLE_W-1:0] sh;
        if (len[1] && xp)
            pos = (idx < PAD_CNT) ? TOP_POS : TOP_POS - (idx - PAD_CNT);
        else if (idx < SAMPLE_CNT)
            pos = TOP_POS - idx;
        else
            pos = '0;
        sh = s >> pos;
        return sh[0];
    endfunction
endpackage

// File: rtl/sat_bitclk_frame.sv
// Bit-clock edge detection and slot framing.
// Assumes sck is synchronous to clk and stays at each level for at least
// one clk period. Reset parks the counter past any slot end so that the
// first falling edge opens a left slot.
module sat_bitclk_frame
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  slot_len_e        len,
    output logic             fall,
    output logic             wrap,
    output logic             ws,
    output logic [CNT_W-1:0] next_idx
);
    logic             sck_q;
    logic [CNT_W-1:0] cnt;

    assign fall     = sck_q & ~sck;
    assign wrap     = fall && (cnt >= last_index(len));
    assign next_idx = wrap ? '0 : cnt + 1'b1;

    // Remember the previous bit-clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Advance bit position and flip word select at slot boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
            ws  <= 1'b1;
        end else if (fall) begin
            cnt <= next_idx;
            if (wrap) ws <= ~ws;
        end
    end
endmodule

// File: rtl/sat_hold_chan.sv
// One channel's holding register and empty flag.
// A host write clears the flag and wins over a same-edge copy into the shifter.
module sat_hold_chan
    import sat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic                load,
    output logic [SAMPLE_W-1:0] hold,
    output logic                empty
);
    // Store host data
    always_ff @(posedge clk) begin
        if (!rst_n)  hold <= '0;
        else if (wr) hold <= wdata;
    end

    // Track whether the stored sample has been consumed
    always_ff @(posedge clk) begin
        if (!rst_n)    empty <= 1'b1;
        else if (wr)   empty <= 1'b0;
        else if (load) empty <= 1'b1;
    end
endmodule

// File: rtl/sat_serializer.sv
// Slot shifter: captures a sample at slot start and drives the serial bit.
// Assumes wrap only occurs together with fall.
module sat_serializer
    import sat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall,
    input  logic                wrap,
    input  logic                pick_left,
    input  logic [CNT_W-1:0]    next_idx,
    input  logic [SAMPLE_W-1:0] hold_l,
    input  logic [SAMPLE_W-1:0] hold_r,
    input  slot_len_e           len,
    input  logic                expand,
    output logic                sdo
);
    logic [SAMPLE_W-1:0] cur;
    logic [SAMPLE_W-1:0] src;

    // Choose the sample feeding this bit
    always_comb begin
        if (wrap) src = pick_left ? hold_l : hold_r;
        else      src = cur;
    end

    // Capture new sample at slot start and emit the next bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            sdo <= 1'b0;
        end else if (fall) begin
            sdo <= slot_bit(src, next_idx, len, expand);
            if (wrap) cur <= src;
        end
    end
endmodule

// File: rtl/sat_irq_decode.sv
// Decodes the three transmit requests from the enable and empty flags.
// Purely combinational from registers, so requests follow them directly.
module sat_irq_decode (
    input  logic irq_en,
    input  logic empty_l,
    input  logic empty_r,
    output logic irq_left,
    output logic irq_right,
    output logic irq_under
);
    // Classify the flag pair into one request
    always_comb begin
        irq_left  = irq_en &  empty_l & ~empty_r;
        irq_right = irq_en & ~empty_l &  empty_r;
        irq_under = irq_en &  empty_l &  empty_r;
    end
endmodule

// File: rtl/sat_tx.sv
// Serial audio stereo transmitter top level.
// Holds the control word, joins framing, per-channel holding registers,
// the shifter and the request decoder. Assumes sck is already synchronous.
module sat_tx
    import sat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                soft_rst,
    input  logic                ctrl_wr,
    input  logic [3:0]          ctrl_din,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wdata,
    output logic                sdo,
    output logic                ws,
    output logic                left_empty,
    output logic                right_empty,
    output logic                irq_left,
    output logic                irq_right,
    output logic                irq_under
);
    ctrl_t               ctrl;
    logic                fall;
    logic                wrap;
    logic [CNT_W-1:0]    next_idx;
    logic [CHANNELS-1:0] ch_wr;
    logic [CHANNELS-1:0] ch_load;
    logic [CHANNELS-1:0] ch_empty;
    logic [SAMPLE_W-1:0] ch_hold [CHANNELS];

    // Control word with software reset of padding and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (soft_rst) begin
            ctrl.irq_en <= 1'b0;
            ctrl.expand <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(ctrl_din);
        end
    end

    sat_bitclk_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .len      (ctrl.len),
        .fall     (fall),
        .wrap     (wrap),
        .ws       (ws),
        .next_idx (next_idx)
    );

    // Channel 0 is left (opened when ws was high), channel 1 is right
    assign ch_wr   = {wr_right, wr_left};
    assign ch_load = {wrap & ~ws, wrap & ws};

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        sat_hold_chan u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (ch_wr[ch]),
            .wdata (wdata),
            .load  (ch_load[ch]),
            .hold  (ch_hold[ch]),
            .empty (ch_empty[ch])
        );
    end

    sat_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .wrap      (wrap),
        .pick_left (ws),
        .next_idx  (next_idx),
        .hold_l    (ch_hold[0]),
        .hold_r    (ch_hold[1]),
        .len       (ctrl.len),
        .expand    (ctrl.expand),
        .sdo       (sdo)
    );

    sat_irq_decode u_irq (
        .irq_en    (ctrl.irq_en),
        .empty_l   (ch_empty[0]),
        .empty_r   (ch_empty[1]),
        .irq_left  (irq_left),
        .irq_right (irq_right),
        .irq_under (irq_under)
    );

    assign left_empty  = ch_empty[0];
    assign right_empty = ch_empty[1];
endmodule

// File: rtl/sat_tx_checker.sv
// Port-level temporal checks for sat_tx, attached by bind.
module sat_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       soft_rst,
    input logic       ctrl_wr,
    input logic [3:0] ctrl_din,
    input logic       wr_left,
    input logic       wr_right,
    input logic       sdo,
    input logic       ws,
    input logic       left_empty,
    input logic       right_empty,
    input logic       irq_left,
    input logic       irq_right,
    input logic       irq_under
);
    logic sck_prev;
    logic seen_fall;

    // Independent record of the previous bit-clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck;
    end

    assign seen_fall = sck_prev & ~sck;

    assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_fall |=> $stable(ws));

    assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_fall |=> $stable(sdo));

    assert_left_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_left |=> !left_empty);

    assert_right_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_right |=> !right_empty);

    assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_left, irq_right, irq_under}));

    assert_under_both_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_under |-> (left_empty && right_empty));

    assert_mask_after_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_din[3]) |=> !(irq_left || irq_right || irq_under));

    assert_soft_drops_requests_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !(irq_left || irq_right || irq_under));
endmodule

bind sat_tx sat_tx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .soft_rst    (soft_rst),
    .ctrl_wr     (ctrl_wr),
    .ctrl_din    (ctrl_din),
    .wr_left     (wr_left),
    .wr_right    (wr_right),
    .sdo         (sdo),
    .ws          (ws),
    .left_empty  (left_empty),
    .right_empty (right_empty),
    .irq_left    (irq_left),
    .irq_right   (irq_right),
    .irq_under   (irq_under)
);

// File: tb/sim_sat_tx.sv
module sim_sat_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        soft_rst = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [3:0]  ctrl_din = 4'h0;
    logic        wr_left = 1'b0;
    logic        wr_right = 1'b0;
    logic [23:0] wdata = 24'h0;
    logic        sdo, ws, left_empty, right_empty, irq_left, irq_right, irq_under;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [23:0] SA = 24'hA5C3F1;
    localparam logic [23:0] SB = 24'h3C0F56;

    always #5 clk = ~clk;

    sat_tx u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .soft_rst(soft_rst),
        .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din), .wr_left(wr_left),
        .wr_right(wr_right), .wdata(wdata), .sdo(sdo), .ws(ws),
        .left_empty(left_empty), .right_empty(right_empty),
        .irq_left(irq_left), .irq_right(irq_right), .irq_under(irq_under)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected slot content built from the requirements
    function automatic logic [31:0] expect_word(input logic [23:0] s, input int bits,
                                                input bit xp);
        if (bits == 16) return {16'h0, s[23:8]};
        if (bits == 24) return {8'h0, s};
        if (xp)         return {{8{s[23]}}, s};
        return {s, {8{s[0]}}};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sck = 1'b0; soft_rst = 1'b0; ctrl_wr = 1'b0;
        wr_left = 1'b0; wr_right = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_ctrl(input bit en, input bit xp, input logic [1:0] len);
        ctrl_wr = 1'b1; ctrl_din = {en, xp, len};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_ch(input bit right, input logic [23:0] d);
        wr_left = !right; wr_right = right; wdata = d;
        @(negedge clk);
        wr_left = 1'b0; wr_right = 1'b0;
    endtask

    task automatic tick();
        sck = 1'b1;
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
    endtask

    task automatic capture(input int bits, input bit exp_ws,
                           output logic [31:0] word, output int ws_bad);
        word = '0; ws_bad = 0;
        for (int i = 0; i < bits; i++) begin
            tick();
            word = {word[30:0], sdo};
            if (ws !== exp_ws) ws_bad++;
        end
    endtask

    task automatic stream_pair(input string req, input logic [1:0] len, input bit xp,
                               input int bits);
        logic [31:0] w;
        int bad;
        do_reset();
        set_ctrl(1'b0, xp, len);
        write_ch(1'b0, SA);
        write_ch(1'b1, SB);
        capture(bits, 1'b0, w, bad);
        chk(w == expect_word(SA, bits, xp), req, "left slot", w, expect_word(SA, bits, xp));
        chk(bad == 0, "R2", "ws low in left slot", bad, 0);
        capture(bits, 1'b1, w, bad);
        chk(w == expect_word(SB, bits, xp), req, "right slot", w, expect_word(SB, bits, xp));
        chk(bad == 0, "R2", "ws high in right slot", bad, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(ws == 1'b1 && sdo == 1'b0, "R1", "ws/sdo after reset", {ws, sdo}, 2'b10);
        chk(left_empty && right_empty, "R1", "flags after reset", {left_empty, right_empty}, 2'b11);
        chk({irq_left, irq_right, irq_under} == 3'b000, "R1", "requests after reset",
            {irq_left, irq_right, irq_under}, 0);
        // Default length is 16 bits: one tick then 15 more form a slot
        write_ch(1'b0, SA);
        begin
            logic [31:0] w;
            int bad;
            capture(16, 1'b0, w, bad);
            chk(w == expect_word(SA, 16, 1'b0), "R1", "default 16-bit slot", w,
                expect_word(SA, 16, 1'b0));
        end
    endtask

    task automatic t_hold_between_edges();
        logic o_sdo, o_ws;
        do_reset();
        set_ctrl(1'b0, 1'b0, 2'b01);
        write_ch(1'b0, SA);
        tick();
        o_sdo = sdo; o_ws = ws;
        chk(sdo == SA[23] && ws == 1'b0, "R2", "first bit is msb", {ws, sdo}, {1'b0, SA[23]});
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo == o_sdo && ws == o_ws, "R2", "outputs hold without falling edge",
            {ws, sdo}, {o_ws, o_sdo});
        sck = 1'b0;
        @(negedge clk);
        chk(sdo == SA[22], "R2", "second bit after fall", sdo, SA[22]);
    endtask

    task automatic t_flags_collision();
        logic [31:0] w;
        int bad;
        do_reset();
        set_ctrl(1'b0, 1'b0, 2'b01);
        write_ch(1'b0, SA);
        chk(!left_empty && right_empty, "R7", "left write clears flag",
            {left_empty, right_empty}, 2'b01);
        tick();
        chk(left_empty, "R7", "left flag set at slot load", left_empty, 1);
        repeat (23 + 24) tick();
        // write on the same edge as the next left load
        sck = 1'b1;
        @(negedge clk);
        sck = 1'b0; wr_left = 1'b1; wdata = SB;
        @(negedge clk);
        wr_left = 1'b0;
        chk(!left_empty, "R7", "write wins over load", left_empty, 0);
        w = {31'h0, sdo};
        for (int i = 0; i < 23; i++) begin
            tick();
            w = {w[30:0], sdo};
        end
        chk(w == {8'h0, SA}, "R7", "old sample sent on collision", w, {8'h0, SA});
        capture(24, 1'b1, w, bad);
        capture(24, 1'b0, w, bad);
        chk(w == {8'h0, SB}, "R7", "new sample in following slot", w, {8'h0, SB});
    endtask

    task automatic t_underrun();
        logic [31:0] w;
        int bad;
        do_reset();
        set_ctrl(1'b1, 1'b0, 2'b01);
        write_ch(1'b0, SA);
        write_ch(1'b1, SB);
        capture(24, 1'b0, w, bad);
        capture(24, 1'b1, w, bad);
        chk(irq_under && left_empty && right_empty, "R8", "underrun flagged",
            {irq_under, left_empty, right_empty}, 3'b111);
        capture(24, 1'b0, w, bad);
        chk(w == {8'h0, SA}, "R8", "left resent", w, {8'h0, SA});
        capture(24, 1'b1, w, bad);
        chk(w == {8'h0, SB}, "R8", "right resent", w, {8'h0, SB});
    endtask

    task automatic t_requests();
        do_reset();
        set_ctrl(1'b1, 1'b0, 2'b01);
        chk({irq_left, irq_right, irq_under} == 3'b001, "R9", "both empty gives underrun",
            {irq_left, irq_right, irq_under}, 3'b001);
        write_ch(1'b0, SA);
        chk({irq_left, irq_right, irq_under} == 3'b010, "R9", "right empty request",
            {irq_left, irq_right, irq_under}, 3'b010);
        write_ch(1'b1, SB);
        chk({irq_left, irq_right, irq_under} == 3'b000, "R9", "no request when full",
            {irq_left, irq_right, irq_under}, 3'b000);
        tick();
        chk({irq_left, irq_right, irq_under} == 3'b100, "R9", "left empty request",
            {irq_left, irq_right, irq_under}, 3'b100);
        // Clear enable: request still present while write is presented
        ctrl_wr = 1'b1; ctrl_din = {1'b0, 1'b0, 2'b01};
        #1;
        chk(irq_left == 1'b1, "R11", "request held during clearing write", irq_left, 1);
        @(negedge clk);
        ctrl_wr = 1'b0;
        chk({irq_left, irq_right, irq_under} == 3'b000, "R11", "request masked after edge",
            {irq_left, irq_right, irq_under}, 3'b000);
        chk(left_empty && !right_empty, "R10", "flags live with enable clear",
            {left_empty, right_empty}, 2'b10);
        repeat (23) tick();
        tick();
        chk(left_empty && right_empty, "R10", "both flags set with enable clear",
            {left_empty, right_empty}, 2'b11);
    endtask

    task automatic t_soft_reset();
        logic [31:0] w;
        int bad;
        do_reset();
        set_ctrl(1'b1, 1'b1, 2'b10);
        write_ch(1'b0, SA);
        chk(irq_right == 1'b1, "R12", "request before soft reset", irq_right, 1);
        soft_rst = 1'b1; ctrl_wr = 1'b1; ctrl_din = 4'b1111;
        @(negedge clk);
        soft_rst = 1'b0; ctrl_wr = 1'b0;
        chk({irq_left, irq_right, irq_under} == 3'b000, "R12", "enable cleared",
            {irq_left, irq_right, irq_under}, 3'b000);
        chk(!left_empty && right_empty, "R12", "flags kept", {left_empty, right_empty}, 2'b01);
        capture(32, 1'b0, w, bad);
        chk(w == expect_word(SA, 32, 1'b0), "R12", "padding cleared, length kept", w,
            expect_word(SA, 32, 1'b0));
    endtask

    initial begin
        t_reset();
        t_hold_between_edges();
        stream_pair("R3", 2'b01, 1'b0, 24);
        stream_pair("R3", 2'b00, 1'b0, 16);
        stream_pair("R4", 2'b10, 1'b0, 32);
        stream_pair("R4", 2'b11, 1'b0, 32);
        stream_pair("R5", 2'b10, 1'b1, 32);
        stream_pair("R6", 2'b01, 1'b1, 24);
        stream_pair("R6", 2'b00, 1'b1, 16);
        t_flags_collision();
        t_underrun();
        t_requests();
        t_soft_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule